// File: doc/BRIEF.md
# Arbiter Request Gate

This block holds a one-byte power-control register in I/O space. Software sets its low bit to stop external bus masters from winning either the primary system bus or the graphics port. The register answers single-byte I/O reads and writes at port 0x0022. It does so only while the port-enable bit of the power-management control register is set. That bit is bit 6 of that register and arrives here as a single input. When the enable is clear, an access to the port is not claimed. The block flags it instead, so the forwarding logic can pass it downstream.

Between the external request pins and the two arbiters, the block inserts a request gate. While the control bit is set, every active-low external request reaches the arbiters as deasserted. This covers the primary-bus requests, the graphics-port requests and the companion's hold request.

The gate applies in two situations:
- **Passive-release mode:** the gate does not close until a hold-acknowledge assertion has been seen. This avoids a deadlock.
- **Transfer in progress:** a transfer already running on a bus delays the gate for that bus until the transfer ends. A cycle that is under way therefore always completes.

Top module: `arb_req_gate`

## Requirements
- R1: After synchronous reset the control bit is 0, a claimed read returns 0x00, and every request output equals its input.
- R2: An I/O read or write is claimed only when the address is 0x0022 and the port-enable input is 1. A claimed read returns the register with bit 0 as the control bit. No other address is ever claimed or flagged for forwarding.
- R3: An access to 0x0022 with the port-enable input at 0 raises the forward flag and not the claim flag. It also leaves the register unchanged. Claim and forward are never high together.
- R4: Register bits 7:1 are reserved: writes to them are ignored and they always read as 0.
- R5: Outside passive-release mode, with no transfer in progress, a claimed write with data bit 0 = 1 forces every request output high from the clock edge that takes the write. The outputs stay high whatever the inputs do.
- R6: In passive-release mode, such a write masks nothing until the active-low hold-acknowledge input is sampled low at a clock edge. Masking starts from that edge.
- R7: A claimed write with data bit 0 = 0 ends masking, or cancels a pending deferred mask, at the edge that takes it. From then on the outputs equal the inputs.
- R8: While a bus's transfer-in-progress input is high, masking of that bus is not applied. It takes effect at the first edge where that input is sampled low. Once applied, masking is not lifted by a later transfer-in-progress input.
- R9: The hold request is gated with the primary-bus requests and follows that bus's transfer-in-progress input.
- R10: The two buses are gated independently: a transfer on one bus delays only that bus's masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_rd | input | 1 | Single-byte I/O read strobe |
| io_wr | input | 1 | Single-byte I/O write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0 unless a claimed read |
| io_claim | output | 1 | Access decoded by this register |
| io_forward | output | 1 | Access to the port while disabled; pass downstream |
| pmc_io_en | input | 1 | Port-enable bit (bit 6) of the power-management control register |
| passive_mode | input | 1 | Companion is in passive-release mode |
| hold_ack_n | input | 1 | Hold acknowledge to companion, active low |
| pci_busy | input | 1 | Primary-bus transfer in progress |
| gfx_busy | input | 1 | Graphics-port transfer in progress |
| pci_req_n_in | input | 5 | External primary-bus requests, active low |
| gfx_req_n_in | input | 1 | External graphics-port requests, active low |
| hold_req_n_in | input | 1 | Companion hold request, active low |
| pci_req_n_out | output | 5 | Gated primary-bus requests to arbiter |
| gfx_req_n_out | output | 1 | Gated graphics requests to arbiter |
| hold_req_n_out | output | 1 | Gated hold request to arbiter |

## Verification
The gate is driven with random request patterns under each known mask state:
- **Unmasked:** checking that the outputs equal the inputs tells "unmasked" apart from "stuck".
- **Masked:** checking all-low inputs against all-high outputs tells "masked" apart from "passing".

Random address, enable and write-data sequences are compared with a bench model of the register. This separates a claim from a forward and a reserved bit from the control bit.

Directed sequences cover three timing cases:
- the hold-acknowledge edge in passive-release mode;
- a cancel while the mask is still pending;
- a transfer held high on only one bus.

Each of these shows in which cycle masking starts and on which bus.

// File: rtl/arb_gate_pkg.sv
package arb_gate_pkg;

    localparam int unsigned IO_AW        = 16;
    localparam int unsigned IO_DW        = 8;
    localparam logic [IO_AW-1:0] GATE_PORT = 16'h0022;
    localparam logic [IO_DW-1:0] GATE_RW_MASK = 8'h01;

    typedef enum logic [1:0] {
        MS_OFF   = 2'd0,
        MS_WAIT  = 2'd1,
        MS_ARMED = 2'd2
    } mask_state_e;

    typedef struct packed {
        logic [IO_AW-1:0] addr;
        logic             rd;
        logic             wr;
        logic [IO_DW-1:0] wdata;
    } io_req_t;

    function automatic logic port_hit(input io_req_t r);
        return (r.rd || r.wr) && (r.addr == GATE_PORT);
    endfunction

    function automatic mask_state_e next_mask_state(
        input mask_state_e cur,
        input logic        wr_hit,
        input logic        wr_bit,
        input logic        passive,
        input logic        ack_seen
    );
        mask_state_e nxt;
        nxt = cur;
        if (wr_hit && !wr_bit) begin
            nxt = MS_OFF;
        end else if (wr_hit && wr_bit && cur == MS_OFF) begin
            nxt = passive ? MS_WAIT : MS_ARMED;
        end else if (cur == MS_WAIT && ack_seen) begin
            nxt = MS_ARMED;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/agate_io_decode.sv
module agate_io_decode
    import arb_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  io_req_t          req,
    input  logic             port_en,
    output logic             claim,
    output logic             forward,
    output logic [IO_DW-1:0] rdata,
    output logic             wr_hit,
    output logic             wr_bit
);

    logic [IO_DW-1:0] reg_q;
    logic             hit;

    always_comb begin
        hit     = port_hit(req);
        claim   = hit && port_en;
        forward = hit && !port_en;
        wr_hit  = claim && req.wr;
        wr_bit  = req.wdata[0];
        rdata   = (claim && req.rd) ? reg_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_q <= '0;
        end else if (wr_hit) begin
            reg_q <= req.wdata & GATE_RW_MASK;
        end
    end

endmodule

// File: rtl/agate_seq.sv
module agate_seq
    import arb_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hit,
    input  logic        wr_bit,
    input  logic        passive_mode,
    input  logic        hold_ack_n,
    output mask_state_e st_q,
    output logic        arm_nxt
);

    mask_state_e st_nxt;

    always_comb begin
        st_nxt  = next_mask_state(st_q, wr_hit, wr_bit, passive_mode, !hold_ack_n);
        arm_nxt = (st_nxt == MS_ARMED);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= MS_OFF;
        end else begin
            st_q <= st_nxt;
        end
    end

endmodule

// File: rtl/agate_lane.sv
module agate_lane #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         arm_nxt,
    input  logic         busy,
    input  logic [W-1:0] req_n_in,
    output logic [W-1:0] req_n_out,
    output logic         masked
);

    always_ff @(posedge clk) begin
        if (rst) begin
            masked <= 1'b0;
        end else begin
            masked <= arm_nxt && (masked || !busy);
        end
    end

    for (genvar i = 0; i < W; i++) begin : g_line
        assign req_n_out[i] = req_n_in[i] | masked;
    end

endmodule

// File: rtl/arb_req_gate.sv
module arb_req_gate
    import arb_gate_pkg::*;
#(
    parameter int unsigned N_PCI = 5,
    parameter int unsigned N_GFX = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      io_addr,
    input  logic             io_rd,
    input  logic             io_wr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             io_claim,
    output logic             io_forward,
    input  logic             pmc_io_en,
    input  logic             passive_mode,
    input  logic             hold_ack_n,
    input  logic             pci_busy,
    input  logic             gfx_busy,
    input  logic [N_PCI-1:0] pci_req_n_in,
    input  logic [N_GFX-1:0] gfx_req_n_in,
    input  logic             hold_req_n_in,
    output logic [N_PCI-1:0] pci_req_n_out,
    output logic [N_GFX-1:0] gfx_req_n_out,
    output logic             hold_req_n_out
);

    localparam int unsigned PRI_W = N_PCI + 1;

    io_req_t          req;
    logic             wr_hit;
    logic             wr_bit;
    mask_state_e      st_q;
    logic             arm_nxt;
    logic             pci_on;
    logic             gfx_on;
    logic [PRI_W-1:0] pri_in;
    logic [PRI_W-1:0] pri_out;

    always_comb begin
        req.addr  = io_addr;
        req.rd    = io_rd;
        req.wr    = io_wr;
        req.wdata = io_wdata;
    end

    agate_io_decode u_dec (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .port_en (pmc_io_en),
        .claim   (io_claim),
        .forward (io_forward),
        .rdata   (io_rdata),
        .wr_hit  (wr_hit),
        .wr_bit  (wr_bit)
    );

    agate_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .wr_hit       (wr_hit),
        .wr_bit       (wr_bit),
        .passive_mode (passive_mode),
        .hold_ack_n   (hold_ack_n),
        .st_q         (st_q),
        .arm_nxt      (arm_nxt)
    );

    assign pri_in = {hold_req_n_in, pci_req_n_in};

    agate_lane #(.W(PRI_W)) u_pri (
        .clk       (clk),
        .rst       (rst),
        .arm_nxt   (arm_nxt),
        .busy      (pci_busy),
        .req_n_in  (pri_in),
        .req_n_out (pri_out),
        .masked    (pci_on)
    );

    assign pci_req_n_out  = pri_out[N_PCI-1:0];
    assign hold_req_n_out = pri_out[PRI_W-1];

    agate_lane #(.W(N_GFX)) u_gfx (
        .clk       (clk),
        .rst       (rst),
        .arm_nxt   (arm_nxt),
        .busy      (gfx_busy),
        .req_n_in  (gfx_req_n_in),
        .req_n_out (gfx_req_n_out),
        .masked    (gfx_on)
    );

endmodule

// File: rtl/arb_req_gate_chk.sv
module arb_req_gate_chk
    import arb_gate_pkg::*;
#(
    parameter int unsigned N_PCI = 5,
    parameter int unsigned N_GFX = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             io_rd,
    input logic             io_wr,
    input logic [7:0]       io_wdata,
    input logic [7:0]       io_rdata,
    input logic             io_claim,
    input logic             io_forward,
    input logic             hold_ack_n,
    input logic             pci_busy,
    input logic             gfx_busy,
    input logic [N_PCI-1:0] pci_req_n_in,
    input logic [N_GFX-1:0] gfx_req_n_in,
    input logic             hold_req_n_in,
    input logic [N_PCI-1:0] pci_req_n_out,
    input logic [N_GFX-1:0] gfx_req_n_out,
    input logic             hold_req_n_out,
    input mask_state_e      st_q,
    input logic             pci_on,
    input logic             gfx_on
);

    AST_CLAIM_FWD_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(io_claim && io_forward)); // R3

    AST_FWD_NO_RDATA: assert property (@(posedge clk) disable iff (rst)
        io_forward |-> (io_rdata == 8'h00)); // R3

    AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (io_claim && io_rd) |-> (io_rdata[7:1] == 7'd0)); // R4

    AST_CLEAR_UNMASKS: assert property (@(posedge clk) disable iff (rst)
        (io_claim && io_wr && !io_wdata[0]) |=>
        (pci_req_n_out == pci_req_n_in && gfx_req_n_out == gfx_req_n_in
         && hold_req_n_out == hold_req_n_in)); // R7

    AST_WAIT_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (st_q == MS_WAIT && hold_ack_n) |=> (st_q != MS_ARMED)); // R6

    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (pci_on && !(io_claim && io_wr && !io_wdata[0])) |=> pci_on); // R5

    AST_PCI_BUSY_DEFERS: assert property (@(posedge clk) disable iff (rst)
        (!pci_on && pci_busy) |=> !pci_on); // R8

    AST_GFX_BUSY_DEFERS: assert property (@(posedge clk) disable iff (rst)
        (!gfx_on && gfx_busy) |=> !gfx_on); // R10

    AST_HOLD_WITH_PCI: assert property (@(posedge clk) disable iff (rst)
        (pci_on) |-> hold_req_n_out); // R9

endmodule

bind arb_req_gate arb_req_gate_chk #(.N_PCI(N_PCI), .N_GFX(N_GFX)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .io_rd          (io_rd),
    .io_wr          (io_wr),
    .io_wdata       (io_wdata),
    .io_rdata       (io_rdata),
    .io_claim       (io_claim),
    .io_forward     (io_forward),
    .hold_ack_n     (hold_ack_n),
    .pci_busy       (pci_busy),
    .gfx_busy       (gfx_busy),
    .pci_req_n_in   (pci_req_n_in),
    .gfx_req_n_in   (gfx_req_n_in),
    .hold_req_n_in  (hold_req_n_in),
    .pci_req_n_out  (pci_req_n_out),
    .gfx_req_n_out  (gfx_req_n_out),
    .hold_req_n_out (hold_req_n_out),
    .st_q           (st_q),
    .pci_on         (pci_on),
    .gfx_on         (gfx_on)
);

// File: tb/arb_req_gate_bench.sv
module arb_req_gate_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_PCI = 5;
    localparam int N_GFX = 1;
    localparam int WD_CYCLES = 20000;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      io_addr = '0;
    logic             io_rd = 1'b0;
    logic             io_wr = 1'b0;
    logic [7:0]       io_wdata = '0;
    logic [7:0]       io_rdata;
    logic             io_claim;
    logic             io_forward;
    logic             pmc_io_en = 1'b0;
    logic             passive_mode = 1'b0;
    logic             hold_ack_n = 1'b1;
    logic             pci_busy = 1'b0;
    logic             gfx_busy = 1'b0;
    logic [N_PCI-1:0] pci_req_n_in = '1;
    logic [N_GFX-1:0] gfx_req_n_in = '1;
    logic             hold_req_n_in = 1'b1;
    logic [N_PCI-1:0] pci_req_n_out;
    logic [N_GFX-1:0] gfx_req_n_out;
    logic             hold_req_n_out;

    int  errors = 0;
    int  checks = 0;
    bit  done = 0;
    int  seed_sink;

    always #(CLK_PERIOD/2) clk = ~clk;

    arb_req_gate #(.N_PCI(N_PCI), .N_GFX(N_GFX)) u_arb_req_gate (
        .clk (clk), .rst (rst),
        .io_addr (io_addr), .io_rd (io_rd), .io_wr (io_wr), .io_wdata (io_wdata),
        .io_rdata (io_rdata), .io_claim (io_claim), .io_forward (io_forward),
        .pmc_io_en (pmc_io_en), .passive_mode (passive_mode), .hold_ack_n (hold_ack_n),
        .pci_busy (pci_busy), .gfx_busy (gfx_busy),
        .pci_req_n_in (pci_req_n_in), .gfx_req_n_in (gfx_req_n_in),
        .hold_req_n_in (hold_req_n_in),
        .pci_req_n_out (pci_req_n_out), .gfx_req_n_out (gfx_req_n_out),
        .hold_req_n_out (hold_req_n_out)
    );

    function automatic logic [31:0] gated(input logic [31:0] v, input bit m);
        return m ? 32'hFFFF_FFFF : v;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        tick();
        io_wr = 1'b0;
    endtask

    // Checks both buses and the hold line against expected mask flags, under a random pattern.
    task automatic chk_out(input bit mp, input bit mg, input string tag);
        logic [N_PCI-1:0] pexp;
        logic [N_GFX-1:0] gexp;
        pci_req_n_in  = N_PCI'($urandom);
        gfx_req_n_in  = N_GFX'($urandom);
        hold_req_n_in = 1'($urandom);
        #1;
        pexp = N_PCI'(gated(32'(pci_req_n_in), mp));
        gexp = N_GFX'(gated(32'(gfx_req_n_in), mg));
        chk(pci_req_n_out == pexp, tag, 32'(pci_req_n_out), 32'(pexp));
        chk(gfx_req_n_out == gexp, tag, 32'(gfx_req_n_out), 32'(gexp));
        chk(hold_req_n_out == (hold_req_n_in | mp), {tag, " R9"},
            32'(hold_req_n_out), 32'(hold_req_n_in | mp));
    endtask

    task automatic chk_all_low(input bit mp, input bit mg, input string tag);
        pci_req_n_in = '0; gfx_req_n_in = '0; hold_req_n_in = 1'b0;
        #1;
        chk(pci_req_n_out == (mp ? '1 : '0), tag, 32'(pci_req_n_out), mp ? 32'h1F : 32'h0);
        chk(gfx_req_n_out == (mg ? '1 : '0), tag, 32'(gfx_req_n_out), 32'(mg));
    endtask

    task automatic io_read_chk(input logic [7:0] exp, input string tag);
        io_addr = 16'h0022; io_rd = 1'b1;
        #1;
        chk(io_claim === 1'b1, tag, 32'(io_claim), 32'd1);
        chk(io_rdata === exp, tag, 32'(io_rdata), 32'(exp));
        io_rd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WD_CYCLES, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit m;
        seed_sink = $urandom(32'h5EED_1234);
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;

        // R1: reset state
        chk_out(0, 0, "R1 reset pass-through");
        pmc_io_en = 1'b1;
        io_read_chk(8'h00, "R1 reset read");

        // R3: disabled port forwards, write has no effect
        pmc_io_en = 1'b0;
        io_addr = 16'h0022; io_rd = 1'b1; #1;
        chk(io_forward === 1'b1 && io_claim === 1'b0, "R3 forward when disabled",
            {io_forward, io_claim}, 32'b10);
        io_rd = 1'b0;
        io_write(16'h0022, 8'h01);
        chk_out(0, 0, "R3 disabled write ignored");
        pmc_io_en = 1'b1;
        io_read_chk(8'h00, "R3 register unchanged");

        // R2: other addresses not claimed nor forwarded
        io_addr = 16'h0023; io_wr = 1'b1; #1;
        chk(io_claim === 1'b0 && io_forward === 1'b0, "R2 other address",
            {io_claim, io_forward}, 32'b00);
        tick(); io_wr = 1'b0;
        io_read_chk(8'h00, "R2 other address write ignored");

        // R4: reserved bits
        io_write(16'h0022, 8'hFE);
        io_read_chk(8'h00, "R4 reserved write ignored");
        chk_out(0, 0, "R4 no mask from reserved bits");
        io_write(16'h0022, 8'hFF);
        io_read_chk(8'h01, "R4 read reserved zero");

        // R5: immediate masking
        chk_all_low(1, 1, "R5 all low masked");
        repeat (4) chk_out(1, 1, "R5 masked random");

        // R7: clear
        io_write(16'h0022, 8'h00);
        chk_all_low(0, 0, "R7 cleared passes");
        chk_out(0, 0, "R7 cleared random");

        // R6: passive-release deferral
        passive_mode = 1'b1; hold_ack_n = 1'b1;
        io_write(16'h0022, 8'h01);
        io_read_chk(8'h01, "R6 bit reads back while pending");
        repeat (3) begin tick(); chk_out(0, 0, "R6 pending no mask"); end
        hold_ack_n = 1'b0; #1;
        chk_out(0, 0, "R6 before ack edge");
        tick(); hold_ack_n = 1'b1;
        chk_all_low(1, 1, "R6 masked after ack");
        tick();
        chk_out(1, 1, "R6 stays masked");
        io_write(16'h0022, 8'h00);
        chk_out(0, 0, "R7 clear after passive mask");

        // R7: cancel pending
        io_write(16'h0022, 8'h01);
        io_write(16'h0022, 8'h00);
        hold_ack_n = 1'b0; tick(); tick(); hold_ack_n = 1'b1;
        chk_all_low(0, 0, "R7 pending cancelled");
        passive_mode = 1'b0;

        // R8 / R10: busy defers per bus
        pci_busy = 1'b1; gfx_busy = 1'b0;
        io_write(16'h0022, 8'h01);
        chk_all_low(0, 1, "R10 gfx masked while pci busy");
        tick(); tick();
        chk_out(0, 1, "R8 pci deferred while busy");
        pci_busy = 1'b0; tick();
        chk_all_low(1, 1, "R8 pci masked after transfer");
        pci_busy = 1'b1; gfx_busy = 1'b1; tick(); tick();
        chk_out(1, 1, "R8 busy does not lift mask");
        pci_busy = 1'b0; gfx_busy = 1'b0;
        io_write(16'h0022, 8'h00);
        gfx_busy = 1'b1;
        io_write(16'h0022, 8'h01);
        chk_all_low(1, 0, "R10 pci masked while gfx busy");
        gfx_busy = 1'b0; tick();
        chk_out(1, 1, "R10 gfx masked after transfer");
        io_write(16'h0022, 8'h00);
        chk_out(0, 0, "R7 final clear");

        // Random phase: R2 R3 R4 R5 R7
        m = 1'b0;
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [7:0]  d;
            bit          en;
            bit          wr;
            bit          hit;
            case ($urandom % 3)
                0: a = 16'h0022;
                1: a = 16'h0023;
                default: a = 16'($urandom);
            endcase
            d  = 8'($urandom);
            en = 1'($urandom);
            wr = 1'($urandom);
            hold_ack_n = 1'($urandom);
            pmc_io_en = en; io_addr = a; io_wdata = d;
            io_wr = wr; io_rd = !wr;
            #1;
            hit = (a == 16'h0022);
            chk(io_claim === (hit && en), "R2 random claim", 32'(io_claim), 32'(hit && en));
            chk(io_forward === (hit && !en), "R3 random forward", 32'(io_forward), 32'(hit && !en));
            if (!wr)
                chk(io_rdata === ((hit && en) ? {7'd0, m} : 8'h00), "R4 random read",
                    32'(io_rdata), (hit && en) ? 32'(m) : 32'd0);
            tick();
            if (wr && hit && en) m = d[0];
            io_wr = 1'b0; io_rd = 1'b0;
            chk_out(m, m, m ? "R5 random masked" : "R7 random unmasked");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule